// File: doc/BRIEF.md
# Atomic Store Access-Control Checker

This block judges whether a conditional compare-and-store access may proceed. It takes the result of address translation, a flag saying whether a data cache exists, and a 6-bit atomic policy register. If the access must trap, it reports the exception cause. Translation faults are checked first. A page that lacks read or write permission comes next. Last comes a 2-bit policy field, chosen by the cache attribute of the page. A zero in the chosen field makes the atomic operation trap.

The verdict is registered. It appears one clock after the request strobe, together with the virtual address of that request. A two-state machine tracks whether a verdict is being shown.
- `ST_IDLE` means nothing is shown.
- `ST_REPORT` means a verdict from the previous cycle is shown.

The transitions are:
- `IDLE_TO_REPORT` on a request.
- `REPORT_STAY` on a back-to-back request.
- `REPORT_TO_IDLE` when the strobe drops.
- `IDLE_STAY` otherwise.

Top module: `atomchk_gate`

## Requirements
- R1: After reset, `exc_valid` is 0, `exc_cause` is 0 and `exc_vaddr` is 0.
- R2: A nonzero `xl_fault` (0 means translation succeeded) is raised as the cause unchanged. It overrides every other check.
- R3: With no fault, if `perm_rd` or `perm_wr` is 0, the cause is 29 (store prohibited). Cause 28 (load prohibited) never comes from this check.
- R4: With permissions granted, the policy field is chosen by the cache attribute. Attribute 0 (bypass) selects `atom_ctl[1:0]`, attribute 1 (write-through) selects `[3:2]`, and attribute 2 (write-back) selects `[5:4]`. A selected field equal to 0 raises cause 3 (load/store error).
- R5: A nonzero selected field raises no exception.
- R6: Attribute 3 (isolate) raises cause 3 whatever `atom_ctl` holds, when a data cache is present.
- R7: Attributes 4 to 7 raise no policy exception.
- R8: When `dcache_present` is 0, field `[1:0]` is used for every attribute, isolate included.
- R9: The outputs update on the clock edge after a cycle with `req_valid` high, and `exc_vaddr` holds that request's `req_vaddr`. After a cycle with `req_valid` low, `exc_valid` is 0. `exc_cause` is 0 whenever `exc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Atomic access request strobe |
| req_vaddr | input | 32 | Virtual address of the access |
| xl_fault | input | 5 | Translation fault cause, 0 = none |
| perm_rd | input | 1 | Page readable |
| perm_wr | input | 1 | Page writable |
| cache_attr | input | 3 | Cache attribute class |
| dcache_present | input | 1 | Data cache configured |
| atom_ctl | input | 6 | Atomic policy register |
| exc_valid | output | 1 | Exception raised |
| exc_cause | output | 5 | Exception cause code |
| exc_vaddr | output | 32 | Address of the judged request |

## Verification
The bench targets the following corner cases:
- **Priority order.** A faulting translation on a page with no permissions must still report the translation cause. A design with the order swapped would report 29 instead.
- **Field selection.** Each attribute is paired with a register that zeroes only one field. Mis-wired field offsets then trap on the wrong attribute.
- **Isolate pages.** These are tried with an all-ones register, with and without a data cache. Dropping the cache-absent override would raise a spurious cause 3.
- **Idle cycles.** Idle cycles between requests catch a flag that sticks high.
- **Random mix.** Seeded random requests cover permission shortfalls, so a design that reported load prohibited or passed a partially writable page would fail.

// File: rtl/atomchk_pkg.sv
package atomchk_pkg;
    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE_PROHIB = 5'd29;
    localparam logic [CAUSE_W-1:0] CAUSE_LS_ERROR     = 5'd3;

    typedef enum logic [2:0] {
        ATTR_BYPASS  = 3'd0,
        ATTR_WTHRU   = 3'd1,
        ATTR_WBACK   = 3'd2,
        ATTR_ISOLATE = 3'd3
    } cattr_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } gate_state_e;
endpackage

// File: rtl/atomchk_perm.sv
module atomchk_perm
    import atomchk_pkg::*;
(
    input  logic [CAUSE_W-1:0] xl_fault,
    input  logic               perm_rd,
    input  logic               perm_wr,
    output logic               perm_hit,
    output logic [CAUSE_W-1:0] perm_cause
);
    always_comb begin
        perm_hit   = 1'b0;
        perm_cause = '0;
        if (xl_fault != '0) begin
            perm_hit   = 1'b1;
            perm_cause = xl_fault;
        end else if (!(perm_rd && perm_wr)) begin
            perm_hit   = 1'b1;
            perm_cause = CAUSE_STORE_PROHIB;
        end
    end
endmodule

// File: rtl/atomchk_policy.sv
module atomchk_policy
    import atomchk_pkg::*;
#(
    parameter int FIELD_W    = 2,
    parameter int NUM_FIELDS = 3,
    localparam int CTL_W     = FIELD_W * NUM_FIELDS
) (
    input  logic [2:0]       cache_attr,
    input  logic             dcache_present,
    input  logic [CTL_W-1:0] atom_ctl,
    output logic             pol_trap
);
    logic [NUM_FIELDS-1:0] fld_zero;
    cattr_e                eff_attr;

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_fld
        assign fld_zero[gi] = (atom_ctl[gi*FIELD_W +: FIELD_W] == '0);
    end

    always_comb begin
        eff_attr = dcache_present ? cattr_e'(cache_attr) : ATTR_BYPASS;
        unique case (eff_attr)
            ATTR_BYPASS:  pol_trap = fld_zero[0];
            ATTR_WTHRU:   pol_trap = fld_zero[1];
            ATTR_WBACK:   pol_trap = fld_zero[2];
            ATTR_ISOLATE: pol_trap = 1'b1;
            default:      pol_trap = 1'b0;
        endcase
    end
endmodule

// File: rtl/atomchk_gate.sv
module atomchk_gate
    import atomchk_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [CAUSE_W-1:0] xl_fault,
    input  logic               perm_rd,
    input  logic               perm_wr,
    input  logic [2:0]         cache_attr,
    input  logic               dcache_present,
    input  logic [5:0]         atom_ctl,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [VA_W-1:0]    exc_vaddr
);
    logic               perm_hit;
    logic [CAUSE_W-1:0] perm_cause;
    logic               pol_trap;
    logic               dec_valid;
    logic [CAUSE_W-1:0] dec_cause;
    gate_state_e        state, state_nx;

    atomchk_perm u_perm (
        .xl_fault   (xl_fault),
        .perm_rd    (perm_rd),
        .perm_wr    (perm_wr),
        .perm_hit   (perm_hit),
        .perm_cause (perm_cause)
    );

    atomchk_policy #(.FIELD_W(2), .NUM_FIELDS(3)) u_pol (
        .cache_attr     (cache_attr),
        .dcache_present (dcache_present),
        .atom_ctl       (atom_ctl),
        .pol_trap       (pol_trap)
    );

    always_comb begin
        dec_valid = perm_hit | pol_trap;
        dec_cause = perm_hit ? perm_cause : (pol_trap ? CAUSE_LS_ERROR : '0);
    end

    // transitions: IDLE_TO_REPORT, REPORT_STAY, REPORT_TO_IDLE, IDLE_STAY
    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_nx = req_valid ? ST_REPORT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_valid <= 1'b0;
            exc_cause <= '0;
            exc_vaddr <= '0;
        end else if (state_nx == ST_REPORT) begin
            exc_valid <= dec_valid;
            exc_cause <= dec_cause;
            exc_vaddr <= req_vaddr;
        end else begin
            exc_valid <= 1'b0;
            exc_cause <= '0;
        end
    end

    a_r2_fault_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xl_fault != '0) |=> (exc_valid && exc_cause == $past(xl_fault)));
    a_r3_store_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xl_fault == '0 && !(perm_rd && perm_wr))
            |=> (exc_valid && exc_cause == 5'd29));
    a_r6_isolate: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xl_fault == '0 && perm_rd && perm_wr && dcache_present
            && cache_attr == 3'd3) |=> (exc_valid && exc_cause == 5'd3));
    a_r8_no_cache: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xl_fault == '0 && perm_rd && perm_wr && !dcache_present)
            |=> (exc_valid == ($past(atom_ctl[1:0]) == 2'b00)));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!exc_valid && state == ST_IDLE));
    a_r9_addr: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (exc_vaddr == $past(req_vaddr) && state == ST_REPORT));
    a_r9_cause_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> exc_cause == '0);
endmodule

// File: tb/sim_atomchk_gate.sv
module sim_atomchk_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [4:0]  xl_fault = '0;
    logic        perm_rd = 1'b0;
    logic        perm_wr = 1'b0;
    logic [2:0]  cache_attr = '0;
    logic        dcache_present = 1'b0;
    logic [5:0]  atom_ctl = '0;
    logic        exc_valid;
    logic [4:0]  exc_cause;
    logic [31:0] exc_vaddr;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    atomchk_gate u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .xl_fault(xl_fault), .perm_rd(perm_rd), .perm_wr(perm_wr),
        .cache_attr(cache_attr), .dcache_present(dcache_present),
        .atom_ctl(atom_ctl), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .exc_vaddr(exc_vaddr)
    );

    // returns {valid, cause}
    function automatic logic [5:0] model(input logic [4:0] f, input logic rd,
            input logic wr, input logic [2:0] at, input logic dc, input logic [5:0] ctl);
        logic [2:0] ea;
        if (f != 0) return {1'b1, f};
        if (!(rd && wr)) return {1'b1, 5'd29};
        ea = dc ? at : 3'd0;
        case (ea)
            3'd0: return (ctl[1:0] == 0) ? {1'b1, 5'd3} : 6'd0;
            3'd1: return (ctl[3:2] == 0) ? {1'b1, 5'd3} : 6'd0;
            3'd2: return (ctl[5:4] == 0) ? {1'b1, 5'd3} : 6'd0;
            3'd3: return {1'b1, 5'd3};
            default: return 6'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] f, input logic rd,
            input logic wr, input logic [2:0] at, input logic dc);
        if (f != 0) return "R2";
        if (!(rd && wr)) return "R3";
        if (!dc) return "R8";
        if (at == 3'd3) return "R6";
        if (at > 3'd3) return "R7";
        return "R4/R5";
    endfunction

    task automatic chk(input string tag, input logic [37:0] act, input logic [37:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: valid/cause/vaddr actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic [31:0] va, input logic [4:0] f, input logic rd,
            input logic wr, input logic [2:0] at, input logic dc, input logic [5:0] ctl);
        logic [5:0] e;
        req_valid = 1'b1; req_vaddr = va; xl_fault = f; perm_rd = rd; perm_wr = wr;
        cache_attr = at; dcache_present = dc; atom_ctl = ctl;
        e = model(f, rd, wr, at, dc, ctl);
        @(negedge clk);
        chk(tag_of(f, rd, wr, at, dc), {exc_valid, exc_cause, exc_vaddr}, {e, va});
    endtask

    task automatic idle_chk(input logic [31:0] held_va);
        req_valid = 1'b0;
        req_vaddr = 32'hDEAD_BEEF;
        xl_fault = 5'd7;
        @(negedge clk);
        chk("R9", {exc_valid, exc_cause, exc_vaddr}, {6'd0, held_va});
    endtask

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        #1;
        chk("R1", {exc_valid, exc_cause, exc_vaddr}, 38'd0);
        @(negedge clk);
        chk("R1", {exc_valid, exc_cause, exc_vaddr}, 38'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corner cases
        run_req(32'h1000, 5'd12, 1'b0, 1'b0, 3'd3, 1'b1, 6'd0);   // R2 priority
        run_req(32'h1004, 5'd0, 1'b1, 1'b0, 3'd2, 1'b1, 6'h3F);   // R3
        run_req(32'h1008, 5'd0, 1'b0, 1'b1, 3'd0, 1'b1, 6'h3F);   // R3
        run_req(32'h100C, 5'd0, 1'b1, 1'b1, 3'd0, 1'b1, 6'h3C);   // R4 bypass zero
        run_req(32'h1010, 5'd0, 1'b1, 1'b1, 3'd1, 1'b1, 6'h3C);   // R5
        run_req(32'h1014, 5'd0, 1'b1, 1'b1, 3'd1, 1'b1, 6'h33);   // R4 wt zero
        run_req(32'h1018, 5'd0, 1'b1, 1'b1, 3'd2, 1'b1, 6'h33);   // R5
        run_req(32'h101C, 5'd0, 1'b1, 1'b1, 3'd2, 1'b1, 6'h0F);   // R4 wb zero
        run_req(32'h1020, 5'd0, 1'b1, 1'b1, 3'd0, 1'b1, 6'h0F);   // R5
        run_req(32'h1024, 5'd0, 1'b1, 1'b1, 3'd3, 1'b1, 6'h3F);   // R6
        idle_chk(32'h1024);                                       // R9
        run_req(32'h1028, 5'd0, 1'b1, 1'b1, 3'd3, 1'b0, 6'h3F);   // R8 isolate overridden
        run_req(32'h102C, 5'd0, 1'b1, 1'b1, 3'd2, 1'b0, 6'h3C);   // R8 bypass field zero
        run_req(32'h1030, 5'd0, 1'b1, 1'b1, 3'd5, 1'b1, 6'h00);   // R7
        run_req(32'h1034, 5'd0, 1'b1, 1'b1, 3'd7, 1'b1, 6'h00);   // R7
        idle_chk(32'h1034);                                       // R9
        idle_chk(32'h1034);                                       // R9
        for (int i = 0; i < 400; i++) begin
            logic [4:0] f;
            f = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
            run_req($urandom, f, ($urandom % 5) != 0, ($urandom % 5) != 0,
                    3'($urandom), 1'($urandom), 6'($urandom));
            if ($urandom % 6 == 0) idle_chk(req_vaddr);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule